// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Data Link

This block is a clocked model of a delay-insensitive point-to-point channel. A word handed over on a local ready/valid port is turned into one wire pair per bit. Each pair is driven to a valid code, and the receiving end decides that a word has arrived only when every pair carries a valid code. No request wire exists: the data wires themselves announce completion. The receiver then raises a single acknowledge wire. The sender answers by pulling every wire back to the all-low spacer. The receiver drops acknowledge once every pair reads the spacer again, and only then may the sender start the next word.

A per-wire fault mask is XORed onto the wires between the two ends. It lets a test disturb the channel so that a pair either stays at the spacer or shows both wires high. A pair with both wires high is an illegal code. It is never taken as data, and it sets an error flag that holds until reset. The disturbed wires are also brought out so the channel can be watched.

Top module: `dualrail_link`

## Requirements
- R1: Bit i of a word is carried on wires 2i (high means logic 0) and 2i+1 (high means logic 1); the code with both wires low is the spacer, and the idle channel shows all wires low.
- R2: While rst_n is low at a clock edge, all wires go low after that edge, acknowledge and the error flag go low, out_valid goes low, and in_ready reads high.
- R3: in_ready is high only while the sender is idle with acknowledge low; a word offered with in_valid while in_ready is high is taken at that edge and its code appears on the wires after that edge.
- R4: Acknowledge rises one cycle after the cycle in which every pair shows a valid code, and out_valid is high for exactly that one cycle with out_data holding the decoded word.
- R5: The sender drives every wire back to low in the cycle after it sees acknowledge high.
- R6: Acknowledge falls one cycle after the cycle in which every pair reads the spacer.
- R7: The sender starts no new word until it has seen acknowledge low after the spacer; in_valid offered while in_ready is low is ignored and delivers no word.
- R8: While any pair still reads the spacer, no word completes: acknowledge stays low and out_valid stays low.
- R9: A pair with both wires high is illegal: it is never taken as data, blocks completion, and sets the error flag one cycle later.
- R10: The error flag, once set, stays high until reset.
- R11: The words delivered on out_data equal the accepted words, in order, one delivery for each accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sender side: a word is offered |
| in_ready | output | 1 | Sender side: the offered word is taken at this edge |
| in_data | input | W | Sender side: word to carry |
| fault_mask | input | 2W | Per-wire disturbance XORed onto the channel wires |
| chan_rails | output | 2W | The channel wires as the receiver sees them |
| chan_ack | output | 1 | Acknowledge wire from receiver to sender |
| out_valid | output | 1 | One-cycle strobe: a word has completed |
| out_data | output | W | Last decoded word |
| err_flag | output | 1 | Sticky flag: an illegal pair code was seen |

## Verification
The link is driven with all-zero, all-one, alternating and walking-one words. Each of these sets a different half of the wire pairs, so a swapped or misrouted rail shows up in both the wire pattern and the decoded word. Back-to-back offers with in_valid held high, and offers made while in_ready is low, test the four-phase spacing and the refusal of early words. Two kinds of fault test follow. In one, a data wire is masked back to low, so completion must wait. In the other, the opposite wire is forced high, so completion is blocked and the error flag must be raised. This tells a detector that waits for all pairs apart from one that fires on the first, and tells legal codes apart from illegal ones.

// File: rtl/dualrail_pkg.sv
package dualrail_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_RTZ  = 2'd2
    } tx_phase_e;

endpackage

// File: rtl/dualrail_detect.sv
module dualrail_detect #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] rails,
    output logic           all_valid,
    output logic           all_null,
    output logic           any_bad,
    output logic [W-1:0]   word
);
    logic [W-1:0] pair_valid;
    logic [W-1:0] pair_null;
    logic [W-1:0] pair_bad;

    for (genvar i = 0; i < W; i++) begin : g_pair
        logic r0;
        logic r1;
        assign r0            = rails[2*i];
        assign r1            = rails[2*i+1];
        assign pair_valid[i] = r0 ^ r1;
        assign pair_null[i]  = ~r0 & ~r1;
        assign pair_bad[i]   = r0 & r1;
        assign word[i]       = r1;
    end

    assign all_valid = &pair_valid;
    assign all_null  = &pair_null;
    assign any_bad   = |pair_bad;
endmodule

// File: rtl/dualrail_tx.sv
module dualrail_tx
    import dualrail_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [W-1:0]   in_data,
    input  logic           ack,
    output logic [2*W-1:0] rails
);
    localparam int NR = 2 * W;

    typedef struct packed {
        tx_phase_e       phase;
        logic [NR-1:0]   rails;
    } tx_state_t;

    tx_state_t s_d, s_q;

    function automatic logic [NR-1:0] encode(input logic [W-1:0] d);
        logic [NR-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[2*i]   = ~d[i];
            r[2*i+1] = d[i];
        end
        return r;
    endfunction

    assign in_ready = (s_q.phase == TX_IDLE) && !ack;
    assign rails    = s_q.rails;

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            TX_IDLE: begin
                if (in_valid && !ack) begin
                    s_d.rails = encode(in_data);
                    s_d.phase = TX_DATA;
                end
            end
            TX_DATA: begin
                if (ack) begin
                    s_d.rails = '0;
                    s_d.phase = TX_RTZ;
                end
            end
            TX_RTZ: begin
                if (!ack) s_d.phase = TX_IDLE;
            end
            default: begin
                s_d.rails = '0;
                s_d.phase = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= TX_IDLE;
            s_q.rails <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/dualrail_rx.sv
module dualrail_rx #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] rails,
    output logic           ack,
    output logic           out_valid,
    output logic [W-1:0]   out_data,
    output logic           err_flag
);
    typedef struct packed {
        logic         ack;
        logic         strobe;
        logic [W-1:0] data;
        logic         err;
    } rx_state_t;

    rx_state_t s_d, s_q;

    logic         all_valid;
    logic         all_null;
    logic         any_bad;
    logic [W-1:0] word;

    dualrail_detect #(.W(W)) u_det (
        .rails     (rails),
        .all_valid (all_valid),
        .all_null  (all_null),
        .any_bad   (any_bad),
        .word      (word)
    );

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        s_d.err    = s_q.err | any_bad;
        if (!s_q.ack) begin
            if (all_valid) begin
                s_d.ack    = 1'b1;
                s_d.strobe = 1'b1;
                s_d.data   = word;
            end
        end else if (all_null) begin
            s_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ack    <= 1'b0;
            s_q.strobe <= 1'b0;
            s_q.data   <= '0;
            s_q.err    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack       = s_q.ack;
    assign out_valid = s_q.strobe;
    assign out_data  = s_q.data;
    assign err_flag  = s_q.err;
endmodule

// File: rtl/dualrail_link.sv
module dualrail_link #(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [W-1:0]     in_data,
    input  logic [2*W-1:0]   fault_mask,
    output logic [2*W-1:0]   chan_rails,
    output logic             chan_ack,
    output logic             out_valid,
    output logic [W-1:0]     out_data,
    output logic             err_flag
);
    logic [2*W-1:0] tx_rails;
    logic           ack_w;

    dualrail_tx #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .ack      (ack_w),
        .rails    (tx_rails)
    );

    assign chan_rails = tx_rails ^ fault_mask;

    dualrail_rx #(.W(W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rails     (chan_rails),
        .ack       (ack_w),
        .out_valid (out_valid),
        .out_data  (out_data),
        .err_flag  (err_flag)
    );

    assign chan_ack = ack_w;
endmodule

// File: rtl/dualrail_link_chk.sv
module dualrail_link_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [2*W-1:0] fault_mask,
    input logic [2*W-1:0] chan_rails,
    input logic           chan_ack,
    input logic           out_valid,
    input logic           err_flag
);
    logic all_v;
    logic all_n;
    logic bad;

    always_comb begin
        all_v = 1'b1;
        all_n = 1'b1;
        bad   = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (chan_rails[2*i] == chan_rails[2*i+1]) all_v = 1'b0;
            if (chan_rails[2*i] || chan_rails[2*i+1]) all_n = 1'b0;
            if (chan_rails[2*i] && chan_rails[2*i+1]) bad = 1'b1;
        end
    end

    // R4
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_ack && all_v) |=> (chan_ack && out_valid));

    // R4
    strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ack && all_n) |=> !chan_ack);

    // R8
    no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_ack && !all_v) |=> (!chan_ack && !out_valid));

    // R9
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> err_flag);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R3
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !chan_ack);

    // R5
    rtz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ack && !in_ready && $stable(chan_ack) && fault_mask == '0
         && $past(fault_mask) == '0 && !$past(in_valid && in_ready)) |=> (chan_rails == '0 || !chan_ack));
endmodule

bind dualrail_link dualrail_link_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .fault_mask (fault_mask),
    .chan_rails (chan_rails),
    .chan_ack   (chan_ack),
    .out_valid  (out_valid),
    .err_flag   (err_flag)
);

// File: tb/sim_dualrail_link.sv
`timescale 1ns/1ps
module sim_dualrail_link;
    localparam int W  = 8;
    localparam int NR = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic [NR-1:0] fault_mask = '0;
    logic [NR-1:0] chan_rails;
    logic          chan_ack;
    logic          out_valid;
    logic [W-1:0]  out_data;
    logic          err_flag;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dualrail_link #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .fault_mask(fault_mask), .chan_rails(chan_rails),
        .chan_ack(chan_ack), .out_valid(out_valid), .out_data(out_data),
        .err_flag(err_flag)
    );

    // behavioural reference
    int            m_phase = 0;   // 0 idle, 1 data, 2 return to zero
    logic [NR-1:0] m_rails = '0;
    logic          m_ack = 1'b0;
    logic          m_ov = 1'b0;
    logic [W-1:0]  m_out = '0;
    logic          m_err = 1'b0;
    logic [W-1:0]  sent_q[$];
    int            delivered = 0;
    int            accepted = 0;

    always @(posedge clk) begin
        logic [NR-1:0] wires;
        bit av, an, ab;
        logic [W-1:0] dec;
        int nphase;
        logic [NR-1:0] nrails;
        logic nack, nov, nerr;
        logic [W-1:0] nout;
        if (!rst_n) begin
            m_phase = 0; m_rails = '0; m_ack = 0; m_ov = 0; m_out = '0; m_err = 0;
            sent_q.delete();
        end else begin
            wires = m_rails ^ fault_mask;
            av = 1; an = 1; ab = 0;
            for (int i = 0; i < W; i++) begin
                if (wires[2*i] == wires[2*i+1]) av = 0;
                if (wires[2*i] | wires[2*i+1]) an = 0;
                if (wires[2*i] & wires[2*i+1]) ab = 1;
                dec[i] = wires[2*i+1];
            end
            nphase = m_phase; nrails = m_rails; nack = m_ack; nov = 0;
            nout = m_out; nerr = m_err | ab;
            if (m_phase == 0 && in_valid && !m_ack) begin
                for (int i = 0; i < W; i++) begin
                    nrails[2*i+1] = in_data[i];
                    nrails[2*i]   = !in_data[i];
                end
                nphase = 1;
                sent_q.push_back(in_data);
                accepted++;
            end else if (m_phase == 1 && m_ack) begin
                nrails = '0; nphase = 2;
            end else if (m_phase == 2 && !m_ack) begin
                nphase = 0;
            end
            if (!m_ack && av) begin
                nack = 1; nov = 1; nout = dec;
            end else if (m_ack && an) begin
                nack = 0;
            end
            m_phase = nphase; m_rails = nrails; m_ack = nack; m_ov = nov;
            m_out = nout; m_err = nerr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 wires", 32'(chan_rails), 32'(m_rails ^ fault_mask));
            chk("R3 in_ready", 32'(in_ready), 32'(m_phase == 0 && !m_ack));
            chk("R4/R6 ack", 32'(chan_ack), 32'(m_ack));
            chk("R4 out_valid", 32'(out_valid), 32'(m_ov));
            chk("R10 err_flag", 32'(err_flag), 32'(m_err));
            if (m_ov) begin
                chk("R4 out_data", 32'(out_data), 32'(m_out));
                if (fault_mask == '0) begin
                    if (sent_q.size() == 0) chk("R11 spurious delivery", 32'd1, 32'd0);
                    else chk("R11 order", 32'(out_data), 32'(sent_q.pop_front()));
                end
                delivered++;
            end
        end
    end

    task automatic send(input logic [W-1:0] d);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] pats[6];
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        idle(3);
        rst_n = 1'b1;
        // R2 reset state
        chk("R2 wires", 32'(chan_rails), 32'd0);
        chk("R2 ack", 32'(chan_ack), 32'd0);
        chk("R2 ready", 32'(in_ready), 32'd1);
        chk("R2 err", 32'(err_flag), 32'd0);
        chk("R2 out_valid", 32'(out_valid), 32'd0);

        // R1 R3 R5 R6 R11: single words with gaps
        foreach (pats[k]) begin
            send(pats[k]);
            idle(6);
        end
        // R1: wire pattern of a known word, one cycle after acceptance
        in_valid = 1'b1; in_data = 8'hC3;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 code of C3", 32'(chan_rails), 32'h0000_A55A);
        @(negedge clk);
        chk("R4 strobe", 32'(out_valid), 32'd1);
        chk("R4 word", 32'(out_data), 32'hC3);
        idle(6);

        // R7: back-to-back with valid held, plus offers while not ready
        in_valid = 1'b1;
        for (int i = 0; i < 30; i++) begin
            in_data = 8'(i * 37 + 11);
            @(negedge clk);
        end
        in_valid = 1'b0;
        idle(8);
        chk("R7 one delivery per acceptance", 32'(delivered), 32'(accepted));

        // R8: word 0x00 -> wire 0 high; mask it low so pair 0 stays spacer
        fault_mask = 16'h0001;
        send(8'h00);
        idle(4);
        chk("R8 held ack", 32'(chan_ack), 32'd0);
        chk("R8 held ready", 32'(in_ready), 32'd0);
        fault_mask = '0;
        idle(8);

        // R9: word 0x00 with wire 1 forced high -> pair 0 = both high
        fault_mask = 16'h0002;
        send(8'h00);
        idle(4);
        chk("R9 no ack on illegal", 32'(chan_ack), 32'd0);
        chk("R9 error set", 32'(err_flag), 32'd1);
        fault_mask = '0;
        idle(8);
        send(8'h3C);
        idle(8);
        chk("R10 error sticky", 32'(err_flag), 32'd1);

        // R2: reset clears the flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R2 err cleared", 32'(err_flag), 32'd0);
        chk("R2 ready after reset", 32'(in_ready), 32'd1);
        send(8'h96);
        idle(8);
        chk("R11 all delivered", 32'(sent_q.size()), 32'd0);
        finish_run();
    end
endmodule